// File: doc/BRIEF.md
# Chip-Select Window Decoder

The decoder compares each incoming 32-bit system address against eight programmable chip-select windows. It drives a one-hot select toward the attached devices and a hit flag. Each window has its own 12-bit configuration word holding a base field, an enable bit and a 4-bit size mask. Only four mask codes are legal, and they give windows of 128, 64, 32 or 16 MB. A window whose base and mask do not fit together, or whose mask code is illegal, takes no part in decoding and raises its own error flag.

Configuration words are loaded through a write-only port that carries a window index and a data word. The address path is purely combinational, so a lookup resolves in the cycle the address is presented. A configuration write becomes visible to lookups from the cycle after the write edge. A write that names a window beyond the last one is dropped and latches a sticky error until reset.

Top module: `cs_window_decoder`

## Requirements
- R1: Only configuration bits 11:8 (mask), 6 (enable) and 5:0 (base) are stored; a written bit 7 has no effect on decoding.
- R2: The legal mask codes are 0x8, 0xC, 0xE and 0xF. Any other code keeps the window out of decoding, and if its enable bit is set its `cfg_err` bit is high.
- R3: A base whose bits 3:0 have a one where the mask has a zero makes the window illegal. It then does not decode and flags `cfg_err` when enabled. Base bits 5:4 never take part in matching.
- R4: An enabled, legal window matches when address bits 27:24 equal base bits 3:0 at every position where the mask has a one. The window spans 16 MB times two to the number of zero mask bits, starting at base[3:0]·16 MB.
- R5: After reset, window 0 holds 0xF40 (enabled, mask 0xF, base 0). Windows 1 to 7 hold 0xF00 (disabled). `idx_err` is low.
- R6: Address bits 31:28 and 23:0 do not affect the decode, so every window repeats every 256 MB.
- R7: When several windows match, only the lowest-numbered one is selected in `cs_onehot`.
- R8: When no window matches, `hit` is low and `cs_onehot` is zero. Otherwise `hit` is high and exactly one select bit is set.
- R9: A write with index 8 or above changes no window and sets `idx_err`, which stays high until reset.
- R10: A configuration write is used by lookups from the cycle after its clock edge. A write whose kept bits equal the stored word leaves the window unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Window index of the write |
| cfg_wdata | input | 12 | Configuration word to write |
| addr | input | 32 | System address to decode |
| cs_onehot | output | 8 | One-hot chip-select, bit n for window n |
| hit | output | 1 | Some window matched the address |
| cfg_err | output | 8 | Per-window illegal-configuration flag |
| idx_err | output | 1 | Sticky flag for an out-of-range write index |

## Verification
A configuration write and a lookup of the same window can share one cycle. The lookup in that cycle must still see the old mapping, and the following cycle must see the new one. The bench provokes this by presenting an address inside a window while rewriting that window's base, mask or enable bit in the same cycle. A behavioural range model is updated only at the clock edge and compared on every cycle, so it judges which mapping each lookup used. Overlapping windows are also rewritten while they are being hit, so priority hand-over between windows is checked on the cycle it happens.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  localparam int CFG_W  = 12;
  localparam int MASK_W = 4;
  localparam int BASE_W = 6;

  localparam logic [CFG_W-1:0] CFG_KEEP = 12'hF7F;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              rsv;
    logic              valid;
    logic [BASE_W-1:0] base;
  } win_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST_ON  = 12'hF40;
  localparam logic [CFG_W-1:0] CFG_RST_OFF = 12'hF00;

  // thermometer-style codes only: 1000, 1100, 1110, 1111
  function automatic logic mask_legal(input logic [MASK_W-1:0] m);
    logic ok;
    case (m)
      4'h8, 4'hC, 4'hE, 4'hF: ok = 1'b1;
      default:                ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cs_wr_decode.sv
module cs_wr_decode #(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 4
) (
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_WIN-1:0] sel,
  output logic               bad_idx
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_WIN; gi++) begin : g_sel
      assign sel[gi] = we && (idx == IDX_W'(gi));
    end
  endgenerate

  assign bad_idx = we && (int'(idx) >= NUM_WIN);

endmodule

// File: rtl/cs_win_slot.sv
module cs_win_slot
  import cs_dec_pkg::*;
#(
  parameter int WIN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [MASK_W-1:0] addr_nib,
  output logic              win_match,
  output logic              cfg_err
);

  localparam logic [CFG_W-1:0] RST_VAL = (WIN_ID == 0) ? CFG_RST_ON : CFG_RST_OFF;

  win_cfg_t          cfg_q;
  win_cfg_t          cfg_d;
  logic [CFG_W-1:0]  kept;
  logic              cfg_en;
  logic              legal;
  logic              active;
  logic [MASK_W-1:0] diff;

  // next state: reload only when a kept bit actually changes
  assign kept   = wdata & CFG_KEEP;
  assign cfg_en = wr_sel && (kept != CFG_W'(cfg_q));

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) cfg_d = win_cfg_t'(kept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= win_cfg_t'(RST_VAL);
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // legality: code from the legal set, no base bit under a zero mask bit
  assign legal  = mask_legal(cfg_q.mask) &&
                  ((cfg_q.base[MASK_W-1:0] & ~cfg_q.mask) == '0);
  assign active = cfg_q.valid && legal;
  assign diff   = (addr_nib ^ cfg_q.base[MASK_W-1:0]) & cfg_q.mask;

  assign win_match = active && (diff == '0);
  assign cfg_err   = cfg_q.valid && !legal;

  // R2 / R3: a flagged window never takes part in the decode
  p_err_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !win_match);

  // R10: rewriting the stored value leaves the window untouched
  p_same_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && (kept == CFG_W'(cfg_q))) |=> $stable(cfg_q));

  // R10: a changing write lands on the next edge
  p_new_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (CFG_W'(cfg_q) == ($past(wdata) & CFG_KEEP)));

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  logic [N:0] taken;

  assign taken[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign grant[gi]   = req[gi] && !taken[gi];
      assign taken[gi+1] = taken[gi] || req[gi];
    end
  endgenerate

  assign any = taken[N];

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] cs_onehot,
  output logic               hit,
  output logic [NUM_WIN-1:0] cfg_err,
  output logic               idx_err
);

  localparam int NIB_HI = REGION_LSB + MASK_W;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [MASK_W-1:0]  addr_nib;
  logic               addr_unused;
  logic [NUM_WIN-1:0] wr_sel;
  logic               bad_idx;
  logic [NUM_WIN-1:0] win_match;
  logic               idx_err_q;
  logic               idx_err_d;
  logic               idx_err_en;

  assign addr_nib    = addr[REGION_LSB +: MASK_W];
  assign addr_unused = ^{addr[ADDR_W-1:NIB_HI], addr[REGION_LSB-1:0]};

  cs_wr_decode #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_wr_decode (
    .we      (cfg_we),
    .idx     (cfg_idx),
    .sel     (wr_sel),
    .bad_idx (bad_idx)
  );

  genvar gw;
  generate
    for (gw = 0; gw < NUM_WIN; gw++) begin : g_win
      cs_win_slot #(.WIN_ID(gw)) u_slot (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .wr_sel    (wr_sel[gw]),
        .wdata     (cfg_wdata),
        .addr_nib  (addr_nib),
        .win_match (win_match[gw]),
        .cfg_err   (cfg_err[gw])
      );
    end
  endgenerate

  cs_prio_pick #(.N(NUM_WIN)) u_prio (
    .req   (win_match),
    .grant (cs_onehot),
    .any   (hit)
  );

  // sticky index error
  assign idx_err_en = bad_idx && !idx_err_q;
  always_comb begin
    idx_err_d = idx_err_q;
    if (idx_err_en) idx_err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     idx_err_q <= 1'b0;
    else if (idx_err_en) idx_err_q <= idx_err_d;
  end
  assign idx_err = idx_err_q;

  // R7: at most one select, and nothing lower-numbered matched
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(cs_onehot));
  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_onehot != '0) |-> ((win_match & (cs_onehot - 1'b1)) == '0));

  // R8: no hit means no select
  p_nohit_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |-> (cs_onehot == '0));

  // R9: bad index raises the flag and it stays up
  p_badidx_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_idx |=> idx_err);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idx_err |=> idx_err);
  p_badidx_nowr_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_idx |-> (wr_sel == '0));

endmodule

// File: tb/tb_cs_window_decoder.sv
module tb_cs_window_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [11:0] cfg_wdata;
  logic [31:0] addr;
  logic [7:0]  cs_onehot;
  logic        hit;
  logic [7:0]  cfg_err;
  logic        idx_err;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done   = 0;
  string cur_req = "R5";

  always #2 clk = ~clk;

  cs_window_decoder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .addr      (addr),
    .cs_onehot (cs_onehot),
    .hit       (hit),
    .cfg_err   (cfg_err),
    .idx_err   (idx_err)
  );

  // behavioural reference: stored words plus sticky flag
  logic [11:0] m_cfg [8];
  bit          m_ierr;

  function automatic bit m_legal(input logic [11:0] c);
    int mk = int'(c[11:8]);
    bit code_ok = (mk == 8) || (mk == 12) || (mk == 14) || (mk == 15);
    return code_ok && ((int'(c[3:0]) & ~mk & 15) == 0);
  endfunction

  function automatic int m_pick(input logic [31:0] a);
    for (int w = 0; w < 8; w++) begin
      logic [11:0] c = m_cfg[w];
      if (c[6] && m_legal(c)) begin
        int zeros = 0;
        longint sz, st, off;
        for (int b = 0; b < 4; b++) if (!c[8+b]) zeros++;
        sz  = longint'(1) << (24 + zeros);
        st  = longint'(c[3:0]) << 24;
        off = longint'(a & 32'h0FFF_FFFF);
        if (off >= st && off < st + sz) return w;
      end
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 8; w++) m_cfg[w] = (w == 0) ? 12'hF40 : 12'hF00;
      m_ierr = 0;
    end else if (cfg_we) begin
      if (cfg_idx >= 4'd8) m_ierr = 1;
      else m_cfg[cfg_idx[2:0]] = cfg_wdata & 12'hF7F;
    end
  end

  initial begin
    for (int w = 0; w < 8; w++) m_cfg[w] = (w == 0) ? 12'hF40 : 12'hF00;
    m_ierr = 0;
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int          p;
      logic [7:0]  e_cs, e_err;
      bit          e_hit;
      p     = m_pick(addr);
      e_cs  = (p >= 0) ? 8'(1 << p) : 8'h00;
      e_hit = (p >= 0);
      for (int w = 0; w < 8; w++) e_err[w] = m_cfg[w][6] && !m_legal(m_cfg[w]);
      checks++;
      if (cs_onehot !== e_cs || hit !== e_hit || cfg_err !== e_err || idx_err !== m_ierr) begin
        errors++;
        $display("FAIL %s addr=%h: cs=%b hit=%b err=%b ierr=%b expected cs=%b hit=%b err=%b ierr=%b",
                 cur_req, addr, cs_onehot, hit, cfg_err, idx_err, e_cs, e_hit, e_err, m_ierr);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic look(input logic [31:0] a);
    addr = a; cfg_we = 1'b0; step();
  endtask

  task automatic wr(input logic [3:0] i, input logic [11:0] d, input logic [31:0] a);
    addr = a; cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d; step();
    cfg_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; addr = '0;
    repeat (4) step();
    // R5: defaults, window 0 covers the lowest 16 MB only
    look(32'h0000_0000);
    rst_n = 1'b1;
    repeat (3) step();
    look(32'h00FF_FFFF);
    look(32'h0100_0000);
    look(32'h0F00_0000);

    // R4: each legal size
    cur_req = "R4";
    wr(4'd1, 12'h848, 32'h0800_0000);
    look(32'h0800_0000); look(32'h0FFF_FFFF); look(32'h07FF_FFFF);
    wr(4'd2, 12'hC44, 32'h0400_0000);
    look(32'h0400_0000); look(32'h07FF_FFFF); look(32'h03FF_FFFF);
    wr(4'd3, 12'hE42, 32'h0200_0000);
    look(32'h0200_0000); look(32'h03FF_FFFF); look(32'h0180_0000);

    // R6: upper and lower address bits ignored
    cur_req = "R6";
    look(32'h1800_0000); look(32'hF000_0010); look(32'h3280_0000); look(32'hE5FF_FFFF);

    // R7: overlap, lowest index wins; hand-over when window 0 drops
    cur_req = "R7";
    wr(4'd4, 12'hF40, 32'h0000_1000);
    look(32'h0000_1000);
    wr(4'd0, 12'hF00, 32'h0000_2000);
    look(32'h0000_2000);
    wr(4'd5, 12'h840, 32'h0C00_0000);
    look(32'h0C00_0000);

    // R2: illegal mask codes
    cur_req = "R2";
    wr(4'd5, 12'h940, 32'h0000_0000);
    look(32'h0900_0000);
    wr(4'd6, 12'h740, 32'h0000_0000);
    look(32'h0000_0000);
    wr(4'd6, 12'h700, 32'h0000_0000);
    look(32'h0000_0000);

    // R3: base bits under zero mask bits; base bits 5:4 ignored
    cur_req = "R3";
    wr(4'd6, 12'hC43, 32'h0300_0000);
    look(32'h0300_0000);
    wr(4'd1, 12'h000, 32'h0F00_0000);
    wr(4'd6, 12'hF6F, 32'h0F00_0000);
    look(32'h0F00_0000); look(32'h0E00_0000);

    // R1: bit 7 dropped
    cur_req = "R1";
    wr(4'd7, 12'h8C8, 32'h0A00_0000);
    look(32'h0A00_0000);
    wr(4'd7, 12'h080, 32'h0A00_0000);
    look(32'h0A00_0000);

    // R10: write and lookup of the same window in one cycle
    cur_req = "R10";
    wr(4'd6, 12'hF4E, 32'h0F00_0000);
    look(32'h0F00_0000); look(32'h0E00_0000);
    wr(4'd6, 12'hF4E, 32'h0E00_0000);
    wr(4'd6, 12'hFCE, 32'h0E00_0000);
    look(32'h0E00_0000);

    // R8: nothing enabled
    cur_req = "R8";
    for (int w = 0; w < 8; w++) wr(4'(w), 12'hF00, 32'h0000_0000);
    look(32'h0000_0000); look(32'h0F80_0000); look(32'hFFFF_FFFF);
    wr(4'd3, 12'hE46, 32'h0600_0000);
    look(32'h0600_0000); look(32'h0800_0000);

    // R9: out-of-range index ignored, flag sticks
    cur_req = "R9";
    wr(4'd8, 12'hF40, 32'h0000_0000);
    look(32'h0000_0000);
    wr(4'd15, 12'h848, 32'h0800_0000);
    look(32'h0800_0000);
    wr(4'd2, 12'hC44, 32'h0400_0000);
    look(32'h0400_0000);
    repeat (3) step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion before %0d cycles", 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule